// File: doc/BRIEF.md
# Serial Transmit Status Flags

This block keeps the two transmit status flags of a serial controller: a buffer-empty flag, which says that the transmit FIFO can take another byte, and an all-sent flag, which says that nothing is left waiting to go out. Three things drive these flags. The first is the FIFO fill level. The second is the mode chosen by the stop-bit field of the transmit-control register: asynchronous or synchronous. The third is a strobe from the shift register that marks the moment the last CRC bit has left it. Software reads the flags through a two-entry status read port.

Each write on the data port pushes one byte into the FIFO. The block hands the oldest byte to the shift register in any cycle where the shift register reports that it is idle. A power-on reset and a soft-reset command act on the two flags in different ways. The FIFO depth and the data width are parameters. The default FIFO depth is a single entry.

Top module: `tx_status_flags`

## Requirements
- R1: After power-on reset (rstN low), status 0 bit 2 (buffer-empty) is 1, status 1 bit 0 (all-sent) is 0, the FIFO is empty and the mode is synchronous. These values hold until the first control write, data push or pop.
- R2: On a control write, a non-zero stop-bit field ctrlData[3:2] selects asynchronous mode and a zero field selects synchronous mode. The other bits of ctrlData have no effect. The mode is held until the next control write.
- R3: In synchronous mode, any control write, accepted push or pop sets all-sent to 1. While the mode stays synchronous, nothing clears it.
- R4: In asynchronous mode, a control write, accepted push or pop loads both flags with the same value: 1 if the FIFO has a free entry after that cycle, 0 if it does not.
- R5: A control write re-evaluates both flags under the newly selected mode. The new values can be read in the cycle right after the write's clock edge.
- R6: In synchronous mode, a crcLast pulse sets buffer-empty to 1, even while the FIFO is full. In asynchronous mode, crcLast has no effect.
- R7: A softRst pulse sets buffer-empty to 1. It leaves all-sent and the FIFO contents unchanged.
- R8: A data write is accepted only when the FIFO has a free entry. A data write into a full FIFO is dropped, and the byte is never sent.
- R9: When shiftIdle is high and the FIFO is not empty, txPop is high in that same cycle and txByte holds the oldest byte. Bytes leave in the order they were written.
- R10: The read port is combinational. With rdSel 0, rdData shows buffer-empty at bit 2. With rdSel 1, rdData shows all-sent at bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| softRst | input | 1 | Soft-reset command strobe |
| ctrlWr | input | 1 | Write strobe for the transmit-control register |
| ctrlData | input | 8 | Transmit-control write data; stop-bit field at [3:2] |
| dataWr | input | 1 | Data register write strobe (FIFO push) |
| dataIn | input | DATA_W | Byte to push |
| shiftIdle | input | 1 | Shift register is idle and can take a byte |
| crcLast | input | 1 | Final CRC bit has cleared the shift register |
| txPop | output | 1 | Byte handed to the shift register this cycle |
| txByte | output | DATA_W | Oldest FIFO byte |
| rdSel | input | 1 | Status register select (0 or 1) |
| rdData | output | 8 | Status register read data |

## Verification
The properties take every input to be a single-cycle, edge-sampled indication: crcLast and softRst are read as strobes, and ctrlData is treated as meaningful only while ctrlWr is high. Soft reset and a mode write can land in the same cycle. Where the two would conflict, the properties exclude that combination explicitly instead of assuming it never happens. The stimulus uses directed sequences for each ordering of pushes, pops, mode writes and resets. A pseudo-random phase then drives every input independently, including conflicting pulses in one cycle, and all of it stays within those edge-sampled single-cycle inputs.

// File: rtl/txsf_pkg.sv
package txsf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic evt;
    logic syncNext;
    logic crcSet;
    logic softSet;
  } txStrobe_t;

  localparam int STATUS0_EMPTY_BIT   = 2;
  localparam int STATUS1_ALLSENT_BIT = 0;
endpackage

// File: rtl/txsf_ctrl.sv
module txsf_ctrl
  import txsf_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int STOP_LSB = 2,
  parameter int STOP_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              dataWr,
  input  logic              shiftIdle,
  input  logic              crcLast,
  input  logic              fifoFull,
  input  logic              fifoNotEmpty,
  output txStrobe_t         strobe,
  output logic              syncMode
);
  logic [STOP_W-1:0] stopField;
  logic              syncNext;

  assign stopField = ctrlData[STOP_LSB +: STOP_W];
  assign syncNext  = ctrlWr ? (stopField == '0) : syncMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncMode <= 1'b1;
    else       syncMode <= syncNext;
  end

  always_comb begin
    strobe.push     = dataWr && !fifoFull;
    strobe.pop      = shiftIdle && fifoNotEmpty;
    strobe.evt      = ctrlWr || strobe.push || strobe.pop;
    strobe.syncNext = syncNext;
    strobe.crcSet   = crcLast && syncNext;
    strobe.softSet  = softRst;
  end
endmodule

// File: rtl/txsf_datapath.sv
module txsf_datapath
  import txsf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdSel,
  output logic [7:0]        rdData,
  output logic [DATA_W-1:0] headByte,
  output logic              fifoFull,
  output logic              fifoNotEmpty,
  output logic              emptyFlag,
  output logic              allSentFlag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt, cntNext;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              spaceNext;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(i)) mem[i] <= dataIn;
    end
  end

  always_comb begin
    headByte = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdPtr == PTR_W'(i)) headByte = mem[i];
    end
  end

  assign cntNext      = cnt + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
  assign spaceNext    = cntNext < CNT_W'(DEPTH);
  assign fifoFull     = cnt == CNT_W'(DEPTH);
  assign fifoNotEmpty = cnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      emptyFlag   <= 1'b1;
      allSentFlag <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      emptyFlag   <= strobe.softSet || strobe.crcSet ||
                     (strobe.evt ? spaceNext : emptyFlag);
      allSentFlag <= strobe.evt ? (strobe.syncNext || spaceNext) : allSentFlag;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) rdData[STATUS1_ALLSENT_BIT] = allSentFlag;
    else       rdData[STATUS0_EMPTY_BIT]   = emptyFlag;
  end
endmodule

// File: rtl/tx_status_flags.sv
module tx_status_flags
  import txsf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 1,
  parameter int STOP_LSB = 2,
  parameter int STOP_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              ctrlWr,
  input  logic [7:0]        ctrlData,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              shiftIdle,
  input  logic              crcLast,
  output logic              txPop,
  output logic [DATA_W-1:0] txByte,
  input  logic              rdSel,
  output logic [7:0]        rdData
);
  txStrobe_t strobe;
  logic      syncMode, fifoFull, fifoNotEmpty, emptyFlag, allSentFlag;

  txsf_ctrl #(.CTRL_W(8), .STOP_LSB(STOP_LSB), .STOP_W(STOP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .ctrlWr(ctrlWr),
    .ctrlData(ctrlData), .dataWr(dataWr), .shiftIdle(shiftIdle),
    .crcLast(crcLast), .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty),
    .strobe(strobe), .syncMode(syncMode)
  );

  txsf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .rdSel(rdSel), .rdData(rdData), .headByte(txByte),
    .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty),
    .emptyFlag(emptyFlag), .allSentFlag(allSentFlag)
  );

  assign txPop = strobe.pop;
endmodule

// File: rtl/tx_status_flags_chk.sv
module tx_status_flags_chk #(
  parameter int STOP_LSB = 2,
  parameter int STOP_W   = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic       ctrlWr,
  input logic [7:0] ctrlData,
  input logic       dataWr,
  input logic       shiftIdle,
  input logic       crcLast,
  input logic       txPop,
  input logic       syncMode,
  input logic       fifoFull,
  input logic       emptyFlag,
  input logic       allSentFlag
);
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(syncMode));

  a_r3_sync_allsent: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlData[STOP_LSB +: STOP_W] == '0) |=> allSentFlag);

  a_r4_async_match: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlData[STOP_LSB +: STOP_W] != '0 && !softRst)
      |=> (allSentFlag == emptyFlag));

  a_r6_crc_sets: assert property (@(posedge clk) disable iff (!rstN)
    (crcLast && syncMode && !ctrlWr) |=> emptyFlag);

  a_r7_soft_keep: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !ctrlWr && !dataWr && !txPop)
      |=> (emptyFlag && allSentFlag == $past(allSentFlag)));

  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !txPop) |=> fifoFull);

  a_r9_pop_idle: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> shiftIdle);
endmodule

bind tx_status_flags tx_status_flags_chk #(.STOP_LSB(STOP_LSB), .STOP_W(STOP_W)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .ctrlWr(ctrlWr),
  .ctrlData(ctrlData), .dataWr(dataWr), .shiftIdle(shiftIdle),
  .crcLast(crcLast), .txPop(txPop), .syncMode(syncMode),
  .fifoFull(fifoFull), .emptyFlag(emptyFlag), .allSentFlag(allSentFlag)
);

// File: tb/sim_tx_status_flags.sv
module sim_tx_status_flags;
  localparam int DEPTH = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0, ctrlWr = 1'b0, dataWr = 1'b0;
  logic       shiftIdle = 1'b0, crcLast = 1'b0, rdSel = 1'b0;
  logic [7:0] ctrlData = '0, dataIn = '0;
  logic       txPop;
  logic [7:0] txByte, rdData;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic  e;
    logic  a;
    string req;
  } item_t;
  item_t expQ[$];

  logic [7:0] mq[$];
  logic       mSync = 1'b1, mEmpty = 1'b1, mAll = 1'b0;

  always #5 clk = ~clk;

  tx_status_flags u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .ctrlWr(ctrlWr),
    .ctrlData(ctrlData), .dataWr(dataWr), .dataIn(dataIn),
    .shiftIdle(shiftIdle), .crcLast(crcLast), .txPop(txPop),
    .txByte(txByte), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus, predict the flags, queue the prediction.
  task automatic cyc(input string req, input logic sr, input logic cw, input logic [7:0] cd,
                     input logic dw, input logic [7:0] di, input logic si, input logic cl);
    logic push, pop, syncN, evt, space;
    logic [7:0] head;
    item_t it;
    @(negedge clk);
    softRst = sr; ctrlWr = cw; ctrlData = cd; dataWr = dw; dataIn = di;
    shiftIdle = si; crcLast = cl;
    push  = dw && (mq.size() < DEPTH);
    pop   = si && (mq.size() > 0);
    head  = (mq.size() > 0) ? mq[0] : 8'h00;
    syncN = cw ? (cd[3:2] == 2'b00) : mSync;
    evt   = cw || push || pop;
    #1;
    chk({req, " R9 pop"}, {7'b0, txPop}, {7'b0, pop});
    if (pop) chk({req, " R9 byte"}, txByte, head);
    if (pop)  void'(mq.pop_front());
    if (push) mq.push_back(di);
    space  = mq.size() < DEPTH;
    mEmpty = sr || (cl && syncN) || (evt ? space : mEmpty);
    mAll   = evt ? (syncN || space) : mAll;
    mSync  = syncN;
    it.e = mEmpty; it.a = mAll; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: after each clock edge, read both status registers and compare.
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      #2;
      it = expQ.pop_front();
      rdSel = 1'b0; #1;
      chk({it.req, " R10 status0"}, rdData, {5'b0, it.e, 2'b0});
      rdSel = 1'b1; #1;
      chk({it.req, " R10 status1"}, rdData, {7'b0, it.a});
      rdSel = 1'b0;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    rdSel = 1'b0; #1; chk("R1 reset status0", rdData, 8'h04);
    rdSel = 1'b1; #1; chk("R1 reset status1", rdData, 8'h00);
    rdSel = 1'b0;
    chk("R1 reset pop", {7'b0, txPop}, 8'h00);

    //   req      sr  cw  cd     dw  di     si  cl
    cyc("R1 idle", 0, 0, 8'h00, 0, 8'h00, 0, 0);
    cyc("R3 R5 sync write", 0, 1, 8'h00, 0, 8'h00, 0, 0);
    cyc("R8 R3 push fills", 0, 0, 8'h00, 1, 8'hA5, 0, 0);
    cyc("R6 crc in sync", 0, 0, 8'h00, 0, 8'h00, 0, 1);
    cyc("R9 pop A5", 0, 0, 8'h00, 0, 8'h00, 1, 0);
    cyc("R8 push 3C", 0, 0, 8'h00, 1, 8'h3C, 0, 0);
    cyc("R8 push dropped", 0, 0, 8'h00, 1, 8'h77, 0, 0);
    cyc("R2 R4 R5 async full", 0, 1, 8'h04, 0, 8'h00, 0, 0);
    cyc("R6 crc async ignored", 0, 0, 8'h00, 0, 8'h00, 0, 1);
    cyc("R7 soft reset", 0, 0, 8'h00, 0, 8'h00, 0, 0);
    cyc("R7 soft reset", 1, 0, 8'h00, 0, 8'h00, 0, 0);
    cyc("R9 R7 pop 3C kept", 0, 0, 8'h00, 0, 8'h00, 1, 0);
    cyc("R8 nothing left", 0, 0, 8'h00, 0, 8'h00, 1, 0);
    cyc("R4 async push", 0, 0, 8'h00, 1, 8'h11, 0, 0);
    cyc("R5 sync while full", 0, 1, 8'h00, 0, 8'h00, 0, 0);
    cyc("R2 async stop 11", 0, 1, 8'h0C, 0, 8'h00, 0, 0);
    cyc("R2 other bits only", 0, 1, 8'hF3, 0, 8'h00, 0, 0);
    cyc("R3 sync pop 11", 0, 0, 8'h00, 0, 8'h00, 1, 0);
    cyc("R2 async stop 10", 0, 1, 8'h08, 0, 8'h00, 0, 0);
    cyc("R4 push pop same", 0, 0, 8'h00, 1, 8'h5A, 1, 0);
    cyc("R9 pop 5A", 0, 0, 8'h00, 0, 8'h00, 1, 0);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R4 R6 R7 random", lfsr[0] & lfsr[5] & lfsr[9], lfsr[1] & lfsr[7],
          {lfsr[15:12], lfsr[3:2], lfsr[11:10]}, lfsr[4], lfsr[15:8],
          lfsr[6] | lfsr[8], lfsr[2] & lfsr[11]);
    end

    cyc("R9 drain", 0, 0, 8'h00, 0, 8'h00, 1, 0);
    repeat (3) @(posedge clk);
    #5;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule